// File: doc/BRIEF.md
# Two-Way Page Descriptor Cache

This block caches page descriptors for a memory management unit. It holds a number of sections, and each section holds a fixed number of rows. Every row has two ways, a left way and a right way. Each way stores an address tag, an access-permission byte and a cleaned descriptor word. One replacement-history flag per row, called U, decides which way a fill overwrites once both ways hold valid data.

A virtual address supplies the section, the row within the section and the tag. The row index is the section number times the rows per section, plus the page-index field. A lookup returns hit or miss, the way that matched, the rebuilt descriptor and the access byte, one cycle after it is presented. A fill takes a virtual address, a segment descriptor word (only its top byte, the access byte, is kept) and a page descriptor. A flush command drops every entry in one section.

Each fill is steered by one of four named placement decisions. FILL_LEFT_EMPTY applies when the left way is invalid: the data goes left and U becomes 0. FILL_RIGHT_EMPTY applies when only the right way is invalid: the data goes right and U becomes 1. ALT_TO_RIGHT applies when both ways are valid and U is 0: the data goes right and U becomes 1. ALT_TO_LEFT applies when both ways are valid and U is 1: the data goes left and U becomes 0. U is written on every fill and changes at no other time.

Top module: `pdc_cache`

## Requirements
- R1: Address fields are taken from the 32-bit virtual address with the default parameters: section = va[31:30], page index = va[13:11], tag = va[29:14]. Row = section*8 + page index. A lookup hits only an entry filled with the same section, page index and tag.
- R2: A lookup presented with lk_valid high at one rising edge raises rsp_valid at that edge and drops it when lk_valid is low. The result reflects the cache contents before that edge. A hit is reported when a valid way in the row holds the tag. rsp_right is 0 for the left way and 1 for the right way, and the left way wins when both ways match.
- R3: On a hit, rsp_pd equals the filled page descriptor ANDed with 0xFFFFF836 with bit 0 forced to 1, and rsp_acc equals bits 31:24 of the filled segment descriptor word. On a miss both are 0.
- R4: A fill into a row whose left way is invalid writes the left way and clears U.
- R5: A fill into a row whose left way is valid and right way is invalid writes the right way and sets U.
- R6: A fill into a row with both ways valid and U = 0 writes the right way and sets U.
- R7: A fill into a row with both ways valid and U = 1 writes the left way and clears U.
- R8: A flush of a section invalidates both ways of every row in that section. It leaves other sections and every U flag unchanged.
- R9: When a fill and a flush name the same section in the same cycle, the flush wins and the fill is dropped. When they name different sections, both take effect.
- R10: Reset invalidates every way and clears every U flag. Outputs are 0 while reset is held.
- R11: A lookup, hit or miss, never changes U.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to look up |
| fill_valid | input | 1 | Fill request |
| fill_va | input | 32 | Virtual address of the descriptor being filled |
| fill_sd | input | 32 | Segment descriptor word; bits 31:24 give the access byte |
| fill_pd | input | 32 | Page descriptor to cache |
| flush_valid | input | 1 | Section flush request |
| flush_sec | input | SEC_W | Section to flush |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_right | output | 1 | Matching way: 0 left, 1 right |
| rsp_pd | output | 32 | Rebuilt page descriptor on a hit |
| rsp_acc | output | 8 | Access byte on a hit |

## Verification
A wrong U flag is invisible on its own. It surfaces only at the next fill into the same row with both ways valid: that fill evicts the wrong way, and the next lookup of the survivor misses or reports the other side one cycle after it is presented. A stuck or lost valid bit shows as a hit after a flush, or a miss after a fill, on the first following lookup of that row. The bench therefore walks one row through every placement decision and probes both residents after each step. The bound checker watches U and the valid bits at the edge after each fill or flush.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // Bits of a page descriptor that survive in the cached copy.
    localparam logic [31:0] PD_KEEP_MASK = 32'hFFFF_F836;

    // Placement decision for one fill.
    typedef enum logic [1:0] {
        FILL_LEFT_EMPTY  = 2'd0,
        FILL_RIGHT_EMPTY = 2'd1,
        ALT_TO_RIGHT     = 2'd2,
        ALT_TO_LEFT      = 2'd3
    } pdc_place_e;

    // Payload kept beside the tag in each way.
    typedef struct packed {
        logic [7:0]  acc;
        logic [31:0] desc;
    } pdc_payload_t;

    function automatic logic [31:0] pdc_clean_desc(input logic [31:0] pd);
        return (pd & PD_KEEP_MASK) | 32'h1;
    endfunction

endpackage

// File: rtl/pdc_place.sv
module pdc_place
    import pdc_pkg::*;
(
    input  logic       left_valid,
    input  logic       right_valid,
    input  logic       used,
    output pdc_place_e place,
    output logic       to_right,
    output logic       next_used
);

    always_comb begin
        if (!left_valid) begin
            place = FILL_LEFT_EMPTY;
        end else if (!right_valid) begin
            place = FILL_RIGHT_EMPTY;
        end else if (!used) begin
            place = ALT_TO_RIGHT;
        end else begin
            place = ALT_TO_LEFT;
        end
    end

    always_comb begin
        unique case (place)
            FILL_LEFT_EMPTY: begin
                to_right  = 1'b0;
                next_used = 1'b0;
            end
            FILL_RIGHT_EMPTY: begin
                to_right  = 1'b1;
                next_used = 1'b1;
            end
            ALT_TO_RIGHT: begin
                to_right  = 1'b1;
                next_used = 1'b1;
            end
            ALT_TO_LEFT: begin
                to_right  = 1'b0;
                next_used = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pdc_store.sv
module pdc_store
    import pdc_pkg::*;
#(
    parameter int ROWS  = 32,
    parameter int TAG_W = 16,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ROW_W-1:0]   wr_row,
    input  logic               wr_right,
    input  logic               wr_used,
    input  logic [TAG_W-1:0]   wr_tag,
    input  pdc_payload_t       wr_data,
    input  logic [ROWS-1:0]    kill_row,
    input  logic [ROW_W-1:0]   rd_row,
    output logic [TAG_W-1:0]   rd_tag_l,
    output logic [TAG_W-1:0]   rd_tag_r,
    output pdc_payload_t       rd_data_l,
    output pdc_payload_t       rd_data_r,
    output logic [ROWS-1:0]    valid_l,
    output logic [ROWS-1:0]    valid_r,
    output logic [ROWS-1:0]    used_q
);

    logic [TAG_W-1:0] tag_l_arr  [ROWS];
    logic [TAG_W-1:0] tag_r_arr  [ROWS];
    pdc_payload_t     data_l_arr [ROWS];
    pdc_payload_t     data_r_arr [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic             vl, vr, u;
        logic [TAG_W-1:0] tl, tr;
        pdc_payload_t     dl, dr;
        logic             hit_row;

        assign hit_row = wr_en && (wr_row == ROW_W'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vl <= 1'b0;
                vr <= 1'b0;
                u  <= 1'b0;
                tl <= '0;
                tr <= '0;
                dl <= '0;
                dr <= '0;
            end else begin
                if (hit_row) begin
                    u <= wr_used;
                    if (wr_right) begin
                        vr <= 1'b1;
                        tr <= wr_tag;
                        dr <= wr_data;
                    end else begin
                        vl <= 1'b1;
                        tl <= wr_tag;
                        dl <= wr_data;
                    end
                end
                if (kill_row[r]) begin
                    vl <= 1'b0;
                    vr <= 1'b0;
                end
            end
        end

        assign valid_l[r]    = vl;
        assign valid_r[r]    = vr;
        assign used_q[r]     = u;
        assign tag_l_arr[r]  = tl;
        assign tag_r_arr[r]  = tr;
        assign data_l_arr[r] = dl;
        assign data_r_arr[r] = dr;
    end

    assign rd_tag_l  = tag_l_arr[rd_row];
    assign rd_tag_r  = tag_r_arr[rd_row];
    assign rd_data_l = data_l_arr[rd_row];
    assign rd_data_r = data_r_arr[rd_row];

endmodule

// File: rtl/pdc_match.sv
module pdc_match
    import pdc_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic             left_valid,
    input  logic             right_valid,
    input  logic [TAG_W-1:0] probe_tag,
    input  logic [TAG_W-1:0] tag_l,
    input  logic [TAG_W-1:0] tag_r,
    input  pdc_payload_t     data_l,
    input  pdc_payload_t     data_r,
    output logic             hit,
    output logic             side_right,
    output pdc_payload_t     data
);

    logic match_l, match_r;

    assign match_l = left_valid  && (tag_l == probe_tag);
    assign match_r = right_valid && (tag_r == probe_tag);

    always_comb begin
        hit        = match_l || match_r;
        side_right = !match_l && match_r;
        if (match_l) begin
            data = data_l;
        end else if (match_r) begin
            data = data_r;
        end else begin
            data = '0;
        end
    end

endmodule

// File: rtl/pdc_cache.sv
module pdc_cache
    import pdc_pkg::*;
#(
    parameter int SEC_W   = 2,
    parameter int PIDX_W  = 3,
    parameter int PIDX_LO = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [31:0]      lk_va,
    input  logic             fill_valid,
    input  logic [31:0]      fill_va,
    input  logic [31:0]      fill_sd,
    input  logic [31:0]      fill_pd,
    input  logic             flush_valid,
    input  logic [SEC_W-1:0] flush_sec,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_right,
    output logic [31:0]      rsp_pd,
    output logic [7:0]       rsp_acc
);

    localparam int ROWS_PER_SEC = 1 << PIDX_W;
    localparam int ROWS         = (1 << SEC_W) * ROWS_PER_SEC;
    localparam int ROW_W        = SEC_W + PIDX_W;
    localparam int TAG_LO       = PIDX_LO + PIDX_W;
    localparam int TAG_W        = 32 - SEC_W - TAG_LO;

    // Address decode: row = section * ROWS_PER_SEC + page index.
    logic [SEC_W-1:0] fill_sec;
    logic [ROW_W-1:0] fill_row, lk_row;
    logic [TAG_W-1:0] fill_tag, lk_tag;

    assign fill_sec = fill_va[31 -: SEC_W];
    assign fill_row = {fill_va[31 -: SEC_W], fill_va[PIDX_LO +: PIDX_W]};
    assign fill_tag = fill_va[TAG_LO +: TAG_W];
    assign lk_row   = {lk_va[31 -: SEC_W], lk_va[PIDX_LO +: PIDX_W]};
    assign lk_tag   = lk_va[TAG_LO +: TAG_W];

    logic unused_bits;
    assign unused_bits = ^{fill_sd[23:0], fill_va[PIDX_LO-1:0], lk_va[PIDX_LO-1:0]};

    // A flush of the same section drops a simultaneous fill.
    logic fill_fire;
    assign fill_fire = fill_valid && !(flush_valid && (flush_sec == fill_sec));

    logic [ROWS-1:0] kill_row;
    for (genvar r = 0; r < ROWS; r++) begin : g_kill
        assign kill_row[r] = flush_valid && (flush_sec == SEC_W'(r >> PIDX_W));
    end

    logic [ROWS-1:0] vl_all, vr_all, u_all;
    logic [TAG_W-1:0] rd_tag_l, rd_tag_r;
    pdc_payload_t     rd_data_l, rd_data_r, wr_data;
    pdc_place_e       place;
    logic             to_right, next_used;

    pdc_place u_place (
        .left_valid  (vl_all[fill_row]),
        .right_valid (vr_all[fill_row]),
        .used        (u_all[fill_row]),
        .place       (place),
        .to_right    (to_right),
        .next_used   (next_used)
    );

    assign wr_data.acc  = fill_sd[31:24];
    assign wr_data.desc = pdc_clean_desc(fill_pd);

    pdc_store #(.ROWS(ROWS), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (fill_fire),
        .wr_row    (fill_row),
        .wr_right  (to_right),
        .wr_used   (next_used),
        .wr_tag    (fill_tag),
        .wr_data   (wr_data),
        .kill_row  (kill_row),
        .rd_row    (lk_row),
        .rd_tag_l  (rd_tag_l),
        .rd_tag_r  (rd_tag_r),
        .rd_data_l (rd_data_l),
        .rd_data_r (rd_data_r),
        .valid_l   (vl_all),
        .valid_r   (vr_all),
        .used_q    (u_all)
    );

    logic         m_hit, m_right;
    pdc_payload_t m_data;

    pdc_match #(.TAG_W(TAG_W)) u_match (
        .left_valid  (vl_all[lk_row]),
        .right_valid (vr_all[lk_row]),
        .probe_tag   (lk_tag),
        .tag_l       (rd_tag_l),
        .tag_r       (rd_tag_r),
        .data_l      (rd_data_l),
        .data_r      (rd_data_r),
        .hit         (m_hit),
        .side_right  (m_right),
        .data        (m_data)
    );

    // Response register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_right <= 1'b0;
            rsp_pd    <= '0;
            rsp_acc   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && m_hit;
            rsp_right <= lk_valid && m_hit && m_right;
            rsp_pd    <= (lk_valid && m_hit) ? m_data.desc : '0;
            rsp_acc   <= (lk_valid && m_hit) ? m_data.acc  : '0;
        end
    end

endmodule

// File: rtl/pdc_cache_chk.sv
module pdc_cache_chk #(
    parameter int SEC_W   = 2,
    parameter int PIDX_W  = 3,
    parameter int PIDX_LO = 11,
    localparam int ROWS   = (1 << SEC_W) << PIDX_W,
    localparam int ROW_W  = SEC_W + PIDX_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             fill_valid,
    input logic [31:0]      fill_va,
    input logic             flush_valid,
    input logic [SEC_W-1:0] flush_sec,
    input logic             rsp_valid,
    input logic [ROWS-1:0]  vl_all,
    input logic [ROWS-1:0]  vr_all,
    input logic [ROWS-1:0]  u_all
);

    logic [ROW_W-1:0] frow;
    logic [SEC_W-1:0] fsec;
    logic             fill_ok, clash;

    assign fsec    = fill_va[31 -: SEC_W];
    assign frow    = {fill_va[31 -: SEC_W], fill_va[PIDX_LO +: PIDX_W]};
    assign clash   = fill_valid && flush_valid && (flush_sec == fsec);
    assign fill_ok = fill_valid && !clash;

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    assert_left_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok && !vl_all[frow] |=> vl_all[$past(frow)] && !u_all[$past(frow)]);

    assert_right_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok && vl_all[frow] && !vr_all[frow] |=> vr_all[$past(frow)] && u_all[$past(frow)]);

    assert_alt_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok && vl_all[frow] && vr_all[frow] && !u_all[frow] |=> u_all[$past(frow)]);

    assert_alt_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok && vl_all[frow] && vr_all[frow] && u_all[frow] |=> !u_all[$past(frow)]);

    for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
        assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            flush_valid && (flush_sec == SEC_W'(r >> PIDX_W)) |=> !vl_all[r] && !vr_all[r]);

        assert_flush_keeps_u_R8: assert property (@(posedge clk) disable iff (!rst_n)
            flush_valid && (flush_sec == SEC_W'(r >> PIDX_W)) |=> $stable(u_all[r]));
    end

    assert_flush_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> !vl_all[$past(frow)] && !vr_all[$past(frow)]);

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (vl_all | vr_all | u_all) == '0);

    assert_lookup_keeps_u_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !fill_valid |=> $stable(u_all));

endmodule

bind pdc_cache pdc_cache_chk #(
    .SEC_W   (SEC_W),
    .PIDX_W  (PIDX_W),
    .PIDX_LO (PIDX_LO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .fill_valid  (fill_valid),
    .fill_va     (fill_va),
    .flush_valid (flush_valid),
    .flush_sec   (flush_sec),
    .rsp_valid   (rsp_valid),
    .vl_all      (vl_all),
    .vr_all      (vr_all),
    .u_all       (u_all)
);

// File: tb/pdc_cache_test.sv
`timescale 1ns/1ps
module pdc_cache_test;

    localparam logic [1:0] OP_FILL = 2'd0;
    localparam logic [1:0] OP_LOOK = 2'd1;
    localparam logic [1:0] OP_FLSH = 2'd2;

    function automatic logic [31:0] mkva(input int s, input int t, input int i);
        logic [31:0] v;
        v = {s[1:0], t[15:0], i[2:0], 11'h0};
        return v;
    endfunction

    function automatic logic [31:0] clean(input logic [31:0] p);
        return (p & 32'hFFFF_F836) | 32'h1;
    endfunction

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] va;
        logic [31:0] pd;
        logic [31:0] sd;
        logic        hit;
        logic        right;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] P1 = 32'hABCD_E8FF, S1 = 32'h5A00_0000;
    localparam logic [31:0] P2 = 32'h1357_9FFF, S2 = 32'hC300_0000;
    localparam logic [31:0] P3 = 32'h0000_F840, S3 = 32'h1100_0000;
    localparam logic [31:0] P4 = 32'hFFFF_FFFF, S4 = 32'h2200_0000;
    localparam logic [31:0] P5 = 32'h2468_ACE0, S5 = 32'h3300_0000;
    localparam logic [31:0] P6 = 32'h8765_4321, S6 = 32'h4400_0000;
    localparam int NV = 27;

    localparam vec_t VECS [NV] = '{
        '{OP_LOOK, mkva(1, 16'h1111, 2), 32'h0, 32'h0, 1'b0, 1'b0, 4'd10}, // R10 empty after reset
        '{OP_FILL, mkva(1, 16'h1111, 2), P1,    S1,    1'b0, 1'b0, 4'd4},
        '{OP_LOOK, mkva(1, 16'h1111, 2), P1,    S1,    1'b1, 1'b0, 4'd4},  // R4 left, R3 data
        '{OP_FILL, mkva(1, 16'h2222, 2), P2,    S2,    1'b0, 1'b0, 4'd5},
        '{OP_LOOK, mkva(1, 16'h2222, 2), P2,    S2,    1'b1, 1'b1, 4'd5},  // R5 right
        '{OP_LOOK, mkva(1, 16'h1111, 2), P1,    S1,    1'b1, 1'b0, 4'd2},  // R2 left still there
        '{OP_FILL, mkva(1, 16'h3333, 2), P3,    S3,    1'b0, 1'b0, 4'd7},
        '{OP_LOOK, mkva(1, 16'h1111, 2), 32'h0, 32'h0, 1'b0, 1'b0, 4'd7},  // R7 left evicted
        '{OP_LOOK, mkva(1, 16'h3333, 2), P3,    S3,    1'b1, 1'b0, 4'd7},
        '{OP_FILL, mkva(1, 16'h4444, 2), P4,    S4,    1'b0, 1'b0, 4'd6},
        '{OP_LOOK, mkva(1, 16'h2222, 2), 32'h0, 32'h0, 1'b0, 1'b0, 4'd6},  // R6 right evicted
        '{OP_LOOK, mkva(1, 16'h4444, 2), P4,    S4,    1'b1, 1'b1, 4'd6},
        '{OP_LOOK, mkva(1, 16'h3333, 2), P3,    S3,    1'b1, 1'b0, 4'd11}, // R11 hit on left
        '{OP_FILL, mkva(1, 16'h5555, 2), P5,    S5,    1'b0, 1'b0, 4'd11},
        '{OP_LOOK, mkva(1, 16'h3333, 2), 32'h0, 32'h0, 1'b0, 1'b0, 4'd11}, // R11 left still chosen
        '{OP_LOOK, mkva(1, 16'h5555, 2), P5,    S5,    1'b1, 1'b0, 4'd11},
        '{OP_FILL, mkva(0, 16'h1111, 5), P6,    S6,    1'b0, 1'b0, 4'd1},
        '{OP_LOOK, mkva(0, 16'h1111, 4), 32'h0, 32'h0, 1'b0, 1'b0, 4'd1},  // R1 other index
        '{OP_LOOK, mkva(2, 16'h1111, 5), 32'h0, 32'h0, 1'b0, 1'b0, 4'd1},  // R1 other section
        '{OP_LOOK, mkva(0, 16'h1111, 5), P6,    S6,    1'b1, 1'b0, 4'd1},
        '{OP_FLSH, mkva(1, 16'h0000, 0), 32'h0, 32'h0, 1'b0, 1'b0, 4'd8},
        '{OP_LOOK, mkva(1, 16'h5555, 2), 32'h0, 32'h0, 1'b0, 1'b0, 4'd8},  // R8 flushed
        '{OP_LOOK, mkva(1, 16'h4444, 2), 32'h0, 32'h0, 1'b0, 1'b0, 4'd8},
        '{OP_LOOK, mkva(0, 16'h1111, 5), P6,    S6,    1'b1, 1'b0, 4'd8},  // R8 other section kept
        '{OP_FILL, mkva(1, 16'h6666, 2), P1,    S1,    1'b0, 1'b0, 4'd4},
        '{OP_LOOK, mkva(1, 16'h6666, 2), P1,    S1,    1'b1, 1'b0, 4'd4},  // R4 refill left
        '{OP_LOOK, mkva(1, 16'h4444, 2), 32'h0, 32'h0, 1'b0, 1'b0, 4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, fill_valid = 1'b0, flush_valid = 1'b0;
    logic [31:0] lk_va = '0, fill_va = '0, fill_sd = '0, fill_pd = '0;
    logic [1:0]  flush_sec = '0;
    logic        rsp_valid, rsp_hit, rsp_right;
    logic [31:0] rsp_pd;
    logic [7:0]  rsp_acc;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pdc_cache uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va),
        .fill_valid(fill_valid), .fill_va(fill_va), .fill_sd(fill_sd), .fill_pd(fill_pd),
        .flush_valid(flush_valid), .flush_sec(flush_sec),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_right(rsp_right),
        .rsp_pd(rsp_pd), .rsp_acc(rsp_acc)
    );

    task automatic check_rsp(input string req, input logic v, input logic h,
                             input logic r, input logic [31:0] pd, input logic [31:0] sd);
        logic [42:0] got, exp;
        got = {rsp_valid, rsp_hit, rsp_right, rsp_pd, rsp_acc};
        exp = {v, h, h && r, h ? clean(pd) : 32'h0, h ? sd[31:24] : 8'h0};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_inputs();
        lk_valid = 1'b0; fill_valid = 1'b0; flush_valid = 1'b0;
    endtask

    task automatic step(input logic [1:0] op, input logic [31:0] va,
                        input logic [31:0] pd, input logic [31:0] sd);
        unique case (op)
            OP_FILL: begin fill_valid = 1'b1; fill_va = va; fill_pd = pd; fill_sd = sd; end
            OP_LOOK: begin lk_valid = 1'b1; lk_va = va; end
            default: begin flush_valid = 1'b1; flush_sec = va[31:30]; end
        endcase
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic h,
                        input logic r, input logic [31:0] pd, input logic [31:0] sd);
        step(OP_LOOK, va, 32'h0, 32'h0);
        check_rsp(req, 1'b1, h, r, pd, sd);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_rsp("R10 outputs in reset", 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].op, VECS[i].va, VECS[i].pd, VECS[i].sd);
            if (VECS[i].op == OP_LOOK) begin
                check_rsp($sformatf("R%0d vector %0d", VECS[i].req, i), 1'b1,
                          VECS[i].hit, VECS[i].right, VECS[i].pd, VECS[i].sd);
            end
        end

        // R2: no lookup, no response
        @(negedge clk);
        check_rsp("R2 idle", 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);

        // R9: fill and flush of the same section, flush wins
        fill_valid = 1'b1; fill_va = mkva(3, 16'h7777, 0); fill_pd = P2; fill_sd = S2;
        flush_valid = 1'b1; flush_sec = 2'd3;
        @(negedge clk);
        clear_inputs();
        look("R9 same section dropped", mkva(3, 16'h7777, 0), 1'b0, 1'b0, 32'h0, 32'h0);

        // R9: different sections, both take effect
        fill_valid = 1'b1; fill_va = mkva(3, 16'h7777, 0); fill_pd = P2; fill_sd = S2;
        flush_valid = 1'b1; flush_sec = 2'd0;
        @(negedge clk);
        clear_inputs();
        look("R9 fill kept", mkva(3, 16'h7777, 0), 1'b1, 1'b0, P2, S2);
        look("R9 other flushed", mkva(0, 16'h1111, 5), 1'b0, 1'b0, 32'h0, 32'h0);

        // R2: both ways hold the same tag, left reported
        step(OP_FILL, mkva(2, 16'h8888, 7), P3, S3);
        step(OP_FILL, mkva(2, 16'h8888, 7), P5, S5);
        look("R2 left priority", mkva(2, 16'h8888, 7), 1'b1, 1'b0, P3, S3);

        // R10: reset mid-run empties the cache
        rst_n = 1'b0;
        @(negedge clk);
        check_rsp("R10 outputs in reset", 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        look("R10 cleared", mkva(3, 16'h7777, 0), 1'b0, 1'b0, 32'h0, 32'h0);
        look("R10 cleared", mkva(2, 16'h8888, 7), 1'b0, 1'b0, 32'h0, 32'h0);

        // R4 after reset: first fill lands left
        step(OP_FILL, mkva(2, 16'h9999, 1), P4, S4);
        look("R4 after reset", mkva(2, 16'h9999, 1), 1'b1, 1'b0, P4, S4);

        summary();
        $finish;
    end

endmodule